// File: doc/BRIEF.md
# Outstanding Line Miss Tracker

The block sits beside a non-blocking data cache behind an in-order pipeline. When a load misses, the pipeline hands over the line address, the word position within the line and the destination register. The load then leaves the pipeline at once. The tracker keeps one entry per missing line. Each entry holds the line address and, for every word slot of the line, the register waiting on that word, if there is one. A later miss to a line that is already tracked joins the existing entry and does not start a second memory transaction. A miss to a new line takes a free entry and starts exactly one memory request in the same cycle.

For every architectural register the tracker also holds a pending flag, which the decode stage reads. A register whose flag is set is still owed a value by memory, so any instruction that reads it must wait at decode. When the memory returns a line, the tracker walks the waiting word slots of the matching entry, lowest slot first, and issues one register writeback per cycle. Each writeback clears the flag of its register. After the last write the entry is freed. Misses that cannot be taken, for whatever reason, are held off with a stall signal and change nothing.

Top module: `msh_file`

## Requirements
- R1: After reset no entry is in use, every pending flag is 0, no memory request or writeback is driven, `fill_ready` is 1, and a miss to any line with an idle destination is taken.
- R2: A miss whose line matches no entry, while a free entry exists, is taken. In the same cycle it drives `mem_req_valid`=1 with `mem_req_line` equal to the miss line. At most one request is issued per cycle.
- R3: A miss whose line matches a tracked entry is merged into that entry's empty word slot. It drives no memory request.
- R4: A miss to an untracked line while all entries are in use raises `miss_stall`, issues no request and leaves all state unchanged.
- R5: A miss that matches a tracked entry whose target word slot is already waited on raises `miss_stall` and does not replace the earlier destination.
- R6: A miss whose destination register is already pending raises `miss_stall`.
- R7: A fill whose line matches an entry is taken when `fill_ready`=1. Starting the cycle after the fill, `wb_valid`=1 for one cycle per waiting slot, in ascending slot order. Each write carries the slot's destination register and word w of `fill_data`, which is bits [32w+31:32w].
- R8: `reg_empty[r]` reads 1 from the cycle after a miss to register r is taken, until the edge at which register r is written back. From the following cycle it reads 0.
- R9: `fill_ready` is 0 while writebacks are in progress. The entry is freed at the edge of its last writeback, and a later miss to the same line then issues a new memory request.
- R10: A miss that matches the entry being drained, or the entry a fill is being taken for in the same cycle, raises `miss_stall`.
- R11: A fill that matches no entry, or that arrives while `fill_ready`=0, is ignored and produces no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A load miss is presented |
| miss_line | input | LINE_W | Line address of the miss |
| miss_word | input | log2(N_WORD) | Word slot within the line |
| miss_dest | input | log2(N_REG) | Destination register of the load |
| miss_stall | output | 1 | Miss not taken this cycle; hold it |
| mem_req_valid | output | 1 | New memory line request |
| mem_req_line | output | LINE_W | Line address of the request |
| fill_valid | input | 1 | Memory returns a line |
| fill_line | input | LINE_W | Line address of the returned line |
| fill_data | input | N_WORD*DATA_W | Returned line, word 0 in the low bits |
| fill_ready | output | 1 | A fill can be taken this cycle |
| wb_valid | output | 1 | Register writeback this cycle |
| wb_reg | output | log2(N_REG) | Register being written |
| wb_data | output | DATA_W | Value written |
| reg_empty | output | N_REG | Per-register pending flag for decode |

## Verification
The stall, memory request and `fill_ready` responses are combinational. Each is due in the same cycle as the stimulus, so the bench drives inputs at the falling edge and compares shortly after. The first writeback appears one cycle after the fill is sampled, and each further waiting slot follows in the next cycle. A pending flag changes one cycle after the edge that takes the miss or performs the write. The bench keeps a reference table of entries, a drain list and the flags. It predicts every output for the current cycle before the rising edge and advances the reference only at that edge, so each comparison falls in the exact cycle the result is due.

// File: rtl/msh_pkg.sv
package msh_pkg;
  typedef enum logic {
    DRN_IDLE = 1'b0,
    DRN_RUN  = 1'b1
  } drn_state_e;
endpackage

// File: rtl/msh_match.sv
module msh_match #(
  parameter int N_ENT  = 4,
  parameter int LINE_W = 28,
  parameter int ENT_W  = 2
) (
  input  logic [N_ENT-1:0]        ent_valid,
  input  logic [N_ENT*LINE_W-1:0] ent_lines,
  input  logic [LINE_W-1:0]       probe,
  output logic                    hit,
  output logic [ENT_W-1:0]        hit_idx
);
  logic [N_ENT-1:0] match_vec;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match_vec[g] = ent_valid[g] && (ent_lines[g*LINE_W +: LINE_W] == probe);
  end

  always_comb begin
    hit     = |match_vec;
    hit_idx = '0;
    for (int i = N_ENT-1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = ENT_W'(i);
    end
  end
endmodule

// File: rtl/msh_free.sv
module msh_free #(
  parameter int N_ENT = 4,
  parameter int ENT_W = 2
) (
  input  logic [N_ENT-1:0] ent_valid,
  output logic             has_free,
  output logic [ENT_W-1:0] free_idx
);
  always_comb begin
    has_free = ~&ent_valid;
    free_idx = '0;
    for (int i = N_ENT-1; i >= 0; i--) begin
      if (!ent_valid[i]) free_idx = ENT_W'(i);
    end
  end
endmodule

// File: rtl/msh_drain.sv
module msh_drain
  import msh_pkg::*;
#(
  parameter int N_WORD = 4,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int ENT_W  = 2,
  parameter int OFS_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_en,
  input  logic [ENT_W-1:0]         start_ent,
  input  logic [N_WORD-1:0]        start_mask,
  input  logic [N_WORD*REG_W-1:0]  start_dests,
  input  logic [N_WORD*DATA_W-1:0] start_data,
  output logic                     busy,
  output logic [ENT_W-1:0]         cur_ent,
  output logic                     wr_valid,
  output logic [REG_W-1:0]         wr_reg,
  output logic [DATA_W-1:0]        wr_data,
  output logic                     last
);
  drn_state_e                state_q, state_d;
  logic [N_WORD-1:0]         mask_q, mask_d, mask_after;
  logic [ENT_W-1:0]          ent_q;
  logic [N_WORD*REG_W-1:0]   dests_q;
  logic [N_WORD*DATA_W-1:0]  data_q;
  logic [REG_W-1:0]          dest_arr [N_WORD];
  logic [DATA_W-1:0]         data_arr [N_WORD];
  logic [OFS_W-1:0]          slot;
  logic                      load_en;
  logic                      ctl_en;

  for (genvar w = 0; w < N_WORD; w++) begin : g_unpack
    assign dest_arr[w] = dests_q[w*REG_W +: REG_W];
    assign data_arr[w] = data_q[w*DATA_W +: DATA_W];
  end

  always_comb begin
    slot = '0;
    for (int w = N_WORD-1; w >= 0; w--) begin
      if (mask_q[w]) slot = OFS_W'(w);
    end
  end

  assign busy       = (state_q == DRN_RUN);
  assign cur_ent    = ent_q;
  assign wr_valid   = busy;
  assign wr_reg     = dest_arr[slot];
  assign wr_data    = data_arr[slot];
  assign mask_after = mask_q & ~(N_WORD'(1) << slot);
  assign last       = busy && (mask_after == '0);
  assign load_en    = !busy && start_en;
  assign ctl_en     = busy || load_en;

  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    if (busy) begin
      mask_d = mask_after;
      if (last) state_d = DRN_IDLE;
    end else if (start_en) begin
      mask_d  = start_mask;
      state_d = DRN_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DRN_IDLE;
      mask_q  <= '0;
    end else if (ctl_en) begin
      state_q <= state_d;
      mask_q  <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      ent_q   <= start_ent;
      dests_q <= start_dests;
      data_q  <= start_data;
    end
  end
endmodule

// File: rtl/msh_regstate.sv
module msh_regstate #(
  parameter int N_REG = 32,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_idx,
  output logic [N_REG-1:0] empty
);
  logic [N_REG-1:0] empty_q, empty_d;
  logic             upd_en;

  assign upd_en = set_en || clr_en;
  assign empty  = empty_q;

  always_comb begin
    empty_d = empty_q;
    if (clr_en) empty_d[clr_idx] = 1'b0;
    if (set_en) empty_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= '0;
    end else if (upd_en) begin
      empty_q <= empty_d;
    end
  end
endmodule

// File: rtl/msh_file.sv
module msh_file #(
  parameter int N_ENT  = 4,
  parameter int N_REG  = 32,
  parameter int N_WORD = 4,
  parameter int LINE_W = 28,
  parameter int DATA_W = 32,
  localparam int ENT_W   = $clog2(N_ENT),
  localparam int REG_W   = $clog2(N_REG),
  localparam int OFS_W   = $clog2(N_WORD),
  localparam int LDATA_W = N_WORD*DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  input  logic [LINE_W-1:0]  miss_line,
  input  logic [OFS_W-1:0]   miss_word,
  input  logic [REG_W-1:0]   miss_dest,
  output logic               miss_stall,
  output logic               mem_req_valid,
  output logic [LINE_W-1:0]  mem_req_line,
  input  logic               fill_valid,
  input  logic [LINE_W-1:0]  fill_line,
  input  logic [LDATA_W-1:0] fill_data,
  output logic               fill_ready,
  output logic               wb_valid,
  output logic [REG_W-1:0]   wb_reg,
  output logic [DATA_W-1:0]  wb_data,
  output logic [N_REG-1:0]   reg_empty
);
  // entry storage
  logic [N_ENT-1:0]        ent_valid_q, valid_d;
  logic [N_WORD-1:0]       ent_wait_q [N_ENT];
  logic [N_WORD-1:0]       wait_d     [N_ENT];
  logic [LINE_W-1:0]       ent_line_q [N_ENT];
  logic [REG_W-1:0]        ent_dest_q [N_ENT][N_WORD];
  logic [N_ENT*LINE_W-1:0] ent_line_flat;

  // lookup results
  logic             m_hit, f_hit, has_free;
  logic [ENT_W-1:0] m_idx, f_idx, free_idx, tgt_idx;

  // drain engine
  logic                    drn_busy, drn_last, drn_wr;
  logic [ENT_W-1:0]        drn_ent;
  logic [N_WORD*REG_W-1:0] fill_dests;

  // control
  logic fill_take, draining_hit, capture_hit, slot_taken, dest_pending;
  logic miss_take, alloc, ctl_en;

  for (genvar e = 0; e < N_ENT; e++) begin : g_flat
    assign ent_line_flat[e*LINE_W +: LINE_W] = ent_line_q[e];
  end

  msh_match #(.N_ENT(N_ENT), .LINE_W(LINE_W), .ENT_W(ENT_W)) u_miss_match (
    .ent_valid (ent_valid_q),
    .ent_lines (ent_line_flat),
    .probe     (miss_line),
    .hit       (m_hit),
    .hit_idx   (m_idx)
  );

  msh_match #(.N_ENT(N_ENT), .LINE_W(LINE_W), .ENT_W(ENT_W)) u_fill_match (
    .ent_valid (ent_valid_q),
    .ent_lines (ent_line_flat),
    .probe     (fill_line),
    .hit       (f_hit),
    .hit_idx   (f_idx)
  );

  msh_free #(.N_ENT(N_ENT), .ENT_W(ENT_W)) u_free (
    .ent_valid (ent_valid_q),
    .has_free  (has_free),
    .free_idx  (free_idx)
  );

  for (genvar w = 0; w < N_WORD; w++) begin : g_fdest
    assign fill_dests[w*REG_W +: REG_W] = ent_dest_q[f_idx][w];
  end

  assign fill_take  = fill_valid && !drn_busy && f_hit;
  assign fill_ready = !drn_busy;

  msh_drain #(
    .N_WORD(N_WORD), .REG_W(REG_W), .DATA_W(DATA_W), .ENT_W(ENT_W), .OFS_W(OFS_W)
  ) u_drain (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_en    (fill_take),
    .start_ent   (f_idx),
    .start_mask  (ent_wait_q[f_idx]),
    .start_dests (fill_dests),
    .start_data  (fill_data),
    .busy        (drn_busy),
    .cur_ent     (drn_ent),
    .wr_valid    (drn_wr),
    .wr_reg      (wb_reg),
    .wr_data     (wb_data),
    .last        (drn_last)
  );

  assign wb_valid = drn_wr;

  // miss acceptance
  assign draining_hit = drn_busy && (drn_ent == m_idx);
  assign capture_hit  = fill_take && (f_idx == m_idx);
  assign slot_taken   = ent_wait_q[m_idx][miss_word];
  assign dest_pending = reg_empty[miss_dest];

  always_comb begin
    miss_stall = 1'b0;
    if (miss_valid) begin
      if (dest_pending)  miss_stall = 1'b1;
      else if (m_hit)    miss_stall = draining_hit || capture_hit || slot_taken;
      else               miss_stall = !has_free;
    end
  end

  assign miss_take     = miss_valid && !miss_stall;
  assign alloc         = miss_take && !m_hit;
  assign tgt_idx       = m_hit ? m_idx : free_idx;
  assign mem_req_valid = alloc;
  assign mem_req_line  = miss_line;

  msh_regstate #(.N_REG(N_REG), .REG_W(REG_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (miss_take),
    .set_idx (miss_dest),
    .clr_en  (drn_wr),
    .clr_idx (wb_reg),
    .empty   (reg_empty)
  );

  // entry next state
  assign ctl_en = drn_last || miss_take;

  always_comb begin
    valid_d = ent_valid_q;
    for (int e = 0; e < N_ENT; e++) wait_d[e] = ent_wait_q[e];
    if (drn_last) begin
      valid_d[drn_ent] = 1'b0;
      wait_d[drn_ent]  = '0;
    end
    if (miss_take) begin
      if (!m_hit) begin
        valid_d[free_idx] = 1'b1;
        wait_d[free_idx]  = '0;
      end
      wait_d[tgt_idx][miss_word] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid_q <= '0;
      for (int e = 0; e < N_ENT; e++) ent_wait_q[e] <= '0;
    end else if (ctl_en) begin
      ent_valid_q <= valid_d;
      for (int e = 0; e < N_ENT; e++) ent_wait_q[e] <= wait_d[e];
    end
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic line_we;
    assign line_we = alloc && (free_idx == ENT_W'(e));
    always_ff @(posedge clk) begin
      if (line_we) ent_line_q[e] <= miss_line;
    end
    for (genvar w = 0; w < N_WORD; w++) begin : g_slot
      logic dest_we;
      assign dest_we = miss_take && (tgt_idx == ENT_W'(e)) && (miss_word == OFS_W'(w));
      always_ff @(posedge clk) begin
        if (dest_we) ent_dest_q[e][w] <= miss_dest;
      end
    end
  end
endmodule

// File: rtl/msh_file_chk.sv
module msh_file_chk #(
  parameter int N_REG = 32,
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_valid,
  input logic [REG_W-1:0] miss_dest,
  input logic             miss_stall,
  input logic             mem_req_valid,
  input logic             fill_ready,
  input logic             wb_valid,
  input logic [REG_W-1:0] wb_reg,
  input logic [N_REG-1:0] reg_empty
);
  // R2
  req_needs_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (miss_valid && !miss_stall));

  // R4
  stall_needs_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_stall |-> miss_valid);

  // R6
  dest_busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && reg_empty[miss_dest]) |-> miss_stall);

  // R8
  take_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !miss_stall) |=> reg_empty[$past(miss_dest)]);

  // R7
  wb_to_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> reg_empty[wb_reg]);

  // R8
  wb_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !reg_empty[$past(wb_reg)]);

  // R9
  drain_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_ready |-> wb_valid);
endmodule

bind msh_file msh_file_chk #(.N_REG(N_REG), .REG_W(REG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_valid    (miss_valid),
  .miss_dest     (miss_dest),
  .miss_stall    (miss_stall),
  .mem_req_valid (mem_req_valid),
  .fill_ready    (fill_ready),
  .wb_valid      (wb_valid),
  .wb_reg        (wb_reg),
  .reg_empty     (reg_empty)
);

// File: tb/tb_msh_file.sv
`timescale 1ns/100ps
module tb_msh_file;
  localparam int NE = 4, NR = 32, NW = 4, LW = 28, DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          miss_valid;
  logic [LW-1:0] miss_line;
  logic [1:0]    miss_word;
  logic [4:0]    miss_dest;
  logic          miss_stall, mem_req_valid;
  logic [LW-1:0] mem_req_line;
  logic          fill_valid;
  logic [LW-1:0] fill_line;
  logic [NW*DW-1:0] fill_data;
  logic          fill_ready, wb_valid;
  logic [4:0]    wb_reg;
  logic [DW-1:0] wb_data;
  logic [NR-1:0] reg_empty;

  int n_chk = 0, n_fail = 0;

  // reference state
  bit            m_valid [NE];
  logic [LW-1:0] m_line  [NE];
  bit            m_wait  [NE][NW];
  logic [4:0]    m_dest  [NE][NW];
  logic [NR-1:0] m_empty;
  bit            d_busy;
  int            d_ent;
  bit            d_mask  [NW];
  logic [4:0]    d_dest  [NW];
  logic [DW-1:0] d_data  [NW];

  always #2.5 clk = ~clk;

  msh_file dut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_line(miss_line), .miss_word(miss_word), .miss_dest(miss_dest),
    .miss_stall(miss_stall), .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data), .fill_ready(fill_ready),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data), .reg_empty(reg_empty)
  );

  function automatic logic [LW-1:0] pool(input int k);
    return 28'h0ABC000 + LW'(k * 3);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic set_idle();
    miss_valid = 1'b0; miss_line = '0; miss_word = '0; miss_dest = '0;
    fill_valid = 1'b0; fill_line = '0; fill_data = '0;
  endtask

  task automatic model_reset();
    for (int e = 0; e < NE; e++) begin
      m_valid[e] = 0;
      for (int w = 0; w < NW; w++) m_wait[e][w] = 0;
    end
    m_empty = '0;
    d_busy  = 0;
    d_ent   = 0;
  endtask

  // Check this cycle's outputs against the reference, then advance it one edge.
  task automatic cycle();
    int    h = -1, fh = -1, fr = -1, ws = -1;
    bit    est = 0, ereq, ftake, left;
    string why = "R2";
    #1;
    for (int e = 0; e < NE; e++) begin
      if (m_valid[e] && m_line[e] == miss_line) h = e;
      if (m_valid[e] && m_line[e] == fill_line) fh = e;
    end
    for (int e = NE-1; e >= 0; e--) if (!m_valid[e]) fr = e;
    ftake = fill_valid && !d_busy && (fh >= 0);
    if (miss_valid) begin
      if (h >= 0) why = "R3";
      if (m_empty[miss_dest]) begin est = 1; why = "R6"; end
      else if (h >= 0) begin
        if ((d_busy && d_ent == h) || (ftake && fh == h)) begin est = 1; why = "R10"; end
        else if (m_wait[h][miss_word]) begin est = 1; why = "R5"; end
      end else if (fr < 0) begin est = 1; why = "R4"; end
    end
    chk(miss_stall == est, why, "miss_stall", miss_stall, est);
    ereq = miss_valid && !est && (h < 0);
    chk(mem_req_valid == ereq, (h >= 0) ? "R3" : why, "mem_req_valid", mem_req_valid, ereq);
    if (ereq) chk(mem_req_line == miss_line, "R2", "mem_req_line", mem_req_line, miss_line);
    chk(fill_ready == !d_busy, "R9", "fill_ready", fill_ready, !d_busy);
    chk(wb_valid == d_busy, "R7", "wb_valid", wb_valid, d_busy);
    if (d_busy) begin
      for (int w = NW-1; w >= 0; w--) if (d_mask[w]) ws = w;
      chk(wb_reg == d_dest[ws], "R7", "wb_reg", wb_reg, d_dest[ws]);
      chk(wb_data == d_data[ws], "R7", "wb_data", wb_data, d_data[ws]);
    end
    chk(reg_empty == m_empty, "R8", "reg_empty", reg_empty, m_empty);
    // advance reference at the edge
    if (d_busy) begin
      m_empty[d_dest[ws]] = 1'b0;
      d_mask[ws] = 0;
      left = 0;
      for (int w = 0; w < NW; w++) if (d_mask[w]) left = 1;
      if (!left) begin
        m_valid[d_ent] = 0;
        for (int w = 0; w < NW; w++) m_wait[d_ent][w] = 0;
        d_busy = 0;
      end
    end
    if (ftake) begin
      d_busy = 1; d_ent = fh;
      for (int w = 0; w < NW; w++) begin
        d_mask[w] = m_wait[fh][w];
        d_dest[w] = m_dest[fh][w];
        d_data[w] = fill_data[w*DW +: DW];
      end
    end
    if (miss_valid && !est) begin
      if (h < 0) begin
        h = fr;
        m_valid[h] = 1; m_line[h] = miss_line;
        for (int w = 0; w < NW; w++) m_wait[h][w] = 0;
      end
      m_wait[h][miss_word] = 1;
      m_dest[h][miss_word] = miss_dest;
      m_empty[miss_dest] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    set_idle();
  endtask

  task automatic miss(input int k, input int w, input int d);
    miss_valid = 1'b1; miss_line = pool(k); miss_word = 2'(w); miss_dest = 5'(d);
  endtask

  task automatic fill(input int k);
    fill_valid = 1'b1; fill_line = pool(k);
    for (int w = 0; w < NW; w++) fill_data[w*DW +: DW] = $urandom;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog: actual running expected finished");
    summary();
  end

  initial begin
    void'($urandom(32'd20251));
    set_idle();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(reg_empty == '0, "R1", "reg_empty", reg_empty, 0);
    chk(!wb_valid && !mem_req_valid && !miss_stall, "R1", "idle outputs",
        {wb_valid, mem_req_valid, miss_stall}, 0);
    chk(fill_ready == 1'b1, "R1", "fill_ready", fill_ready, 1);
    @(negedge clk);

    miss(0, 1, 3); cycle();              // R2 allocate
    miss(0, 2, 4); cycle();              // R3 merge
    miss(0, 1, 5); cycle();              // R5 slot taken
    miss(1, 0, 3); cycle();              // R6 destination pending
    miss(1, 0, 6); cycle();
    miss(2, 3, 7); cycle();
    miss(3, 0, 8); cycle();
    miss(4, 0, 9); cycle();              // R4 table full
    fill(4); cycle();                    // R11 unmatched fill
    #1;
    chk(!wb_valid, "R11", "wb after unmatched fill", wb_valid, 0);
    @(negedge clk);
    fill(0); cycle();                    // R7 drain line 0
    miss(0, 0, 10); fill(1); cycle();    // R10 draining entry, R11 busy fill
    cycle();
    #1;
    chk(!wb_valid, "R11", "wb after ignored fill", wb_valid, 0);
    @(negedge clk);
    miss(0, 0, 11); cycle();             // R9 line re-requested after free
    fill(1); miss(1, 2, 12); cycle();    // R10 capture in same cycle
    cycle();
    fill(2); cycle(); cycle();
    fill(3); cycle(); cycle();
    fill(0); cycle(); cycle();

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(9) < 6) miss($urandom_range(5), $urandom_range(3), $urandom_range(31));
      if ($urandom_range(9) < 2) fill($urandom_range(5));
      cycle();
    end
    for (int i = 0; i < 6; i++) begin
      fill(i); cycle(); repeat (4) cycle();
    end
    summary();
  end
endmodule